// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects thirty-two interrupt request lines into a status register and routes every enabled request to one of two processor-facing outputs: a normal interrupt line or a critical interrupt line. Each request can be programmed to be level-type, with its status bit tracking the line, or edge-type, with its status bit latching on assertion until software clears it. A per-line polarity control inverts a raw line before any of that logic sees it.

For requests routed to the critical class, the block also produces a vector address that software can read to jump straight to the handler. The vector is a programmable base plus a 512-byte stride times the position of the winning request. The scan that picks the winner can run upward from bit 0 or downward from bit 31. A parameter removes the vector logic entirely for instances that do not need it. Software talks to the block through a simple synchronous register port with a word address, a write strobe, write data and read data that is valid in the same cycle as the address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Request input n drives status bit (31 - n); input 0 lands in the most significant bit.
- R2: With its trigger bit (register offset 5) at 1, a line is edge-type: a rising edge of the line sets the status bit, and the bit stays set after the line falls.
- R3: With its trigger bit at 0, a line is level-type: each time the line changes, its status bit takes the new line value.
- R4: Writing offset 0 clears every status bit written as 1, then sets again every level-type bit whose line is still asserted.
- R5: Writing offset 1 ORs the written value into status; reading offset 0 or 1 returns status.
- R6: Reading offset 6 returns status AND enable (enable at offset 2); writes to offsets 6 and 7 change nothing.
- R7: The normal output is high when any bit of status AND enable AND NOT critical-select (offset 3) is set; the critical output is high when any bit of status AND enable AND critical-select is set.
- R8: With a critical request pending, offset 7 reads the vector config (offset 8) with its low two bits cleared plus 512 times the winner's position; vector config bit 0 = 0 picks the lowest set bit with position equal to its index, bit 0 = 1 picks the highest set bit with position (31 - index).
- R9: Offset 7 reads 0 whenever no critical request is pending.
- R10: A write to offset 8 stores the value with bit 1 forced to 0.
- R11: A polarity bit of 1 (offset 4) inverts the corresponding line before the trigger logic.
- R12: Reset clears every register; unused offsets read 0; with the vector feature disabled, offsets 7 and 8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Request lines, input n maps to status bit 31-n |
| bus_addr | input | 4 | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_norm_o | output | 1 | Normal-class interrupt |
| irq_crit_o | output | 1 | Critical-class interrupt |

## Verification
The bench targets the clear write on a level line that is still held, where a design that forgot the re-OR would drop a live request, and the edge line that falls before software clears it, where a design that tracked the level would lose the event. It drives two critical requests at once and reads the vector in both scan directions, catching a reversed priority or an offset counted from the wrong end, and it writes a config with bit 1 set to catch a stored bit leaking into the vector. Writes to the read-only offsets followed by reads catch a decoder that lets them reach status or enable, and a second instance without vectors must read zero at offsets 7 and 8.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned IVC_DW = 32;
  localparam int unsigned IVC_AW = 4;

  typedef enum logic [IVC_AW-1:0] {
    OFS_STATUS = 4'd0,
    OFS_SET    = 4'd1,
    OFS_ENABLE = 4'd2,
    OFS_CRIT   = 4'd3,
    OFS_POL    = 4'd4,
    OFS_TRIG   = 4'd5,
    OFS_MASKED = 4'd6,
    OFS_VECTOR = 4'd7,
    OFS_VCFG   = 4'd8
  } ivc_ofs_e;
endpackage

// File: rtl/ivc_status.sv
module ivc_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] trig_i,
  input  logic         clr_we_i,
  input  logic         set_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, chg, lvl_chg;

  always_comb begin
    rise    = req_i & ~prev_q;
    chg     = req_i ^ prev_q;
    lvl_chg = chg & ~trig_i;
    status_d = status_q;
    if (clr_we_i) status_d = (status_d & ~wdata_i) | (req_i & ~trig_i);
    if (set_we_i) status_d = status_d | wdata_i;
    status_d = status_d | (rise & trig_i);
    status_d = (status_d & ~lvl_chg) | (lvl_chg & req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      prev_q   <= '0;
    end else begin
      status_q <= status_d;
      prev_q   <= req_i;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs
  import ivc_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter bit          VEC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IVC_AW-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      enable_o,
  output logic [W-1:0]      crit_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      trig_o,
  output logic [W-1:0]      vcfg_o
);
  logic [W-1:0] en_q, crit_q, pol_q, trig_q;
  logic [W-1:0] en_d, crit_d, pol_d, trig_d;
  logic en_ce, crit_ce, pol_ce, trig_ce;

  always_comb begin
    en_ce   = we_i && (addr_i == OFS_ENABLE);
    crit_ce = we_i && (addr_i == OFS_CRIT);
    pol_ce  = we_i && (addr_i == OFS_POL);
    trig_ce = we_i && (addr_i == OFS_TRIG);
    en_d    = en_ce   ? wdata_i : en_q;
    crit_d  = crit_ce ? wdata_i : crit_q;
    pol_d   = pol_ce  ? wdata_i : pol_q;
    trig_d  = trig_ce ? wdata_i : trig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else begin
      en_q   <= en_d;
      crit_q <= crit_d;
      pol_q  <= pol_d;
      trig_q <= trig_d;
    end
  end

  generate
    if (VEC_EN) begin : g_vcfg
      logic [W-1:0] vcfg_q, vcfg_d;
      logic vcfg_ce;
      always_comb begin
        vcfg_ce = we_i && (addr_i == OFS_VCFG);
        vcfg_d  = vcfg_ce ? (wdata_i & ~(W'(2))) : vcfg_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vcfg_q <= '0;
        else        vcfg_q <= vcfg_d;
      end
      assign vcfg_o = vcfg_q;
    end else begin : g_no_vcfg
      assign vcfg_o = '0;
    end
  endgenerate

  assign enable_o = en_q;
  assign crit_o   = crit_q;
  assign pol_o    = pol_q;
  assign trig_o   = trig_q;
endmodule

// File: rtl/ivc_vector.sv
module ivc_vector #(
  parameter int unsigned W        = 32,
  parameter bit          VEC_EN   = 1'b1,
  parameter int unsigned STRIDE_SH = 9
) (
  input  logic [W-1:0] crit_pend_i,
  input  logic [W-1:0] vcfg_i,
  output logic [W-1:0] vec_o
);
  localparam int unsigned PW = $clog2(W);

  generate
    if (VEC_EN) begin : g_vec
      logic [PW-1:0] pos;
      logic          found;
      logic [W-1:0]  offs;
      always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int k = 0; k < W; k++) begin
          if (!found && crit_pend_i[vcfg_i[0] ? (W-1-k) : k]) begin
            pos   = PW'(k);
            found = 1'b1;
          end
        end
        offs  = W'(pos) << STRIDE_SH;
        vec_o = found ? ({vcfg_i[W-1:2], 2'b00} + offs) : '0;
      end
    end else begin : g_no_vec
      assign vec_o = '0;
    end
  endgenerate
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter bit          VEC_EN  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic [IVC_AW-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [NUM_SRC-1:0]  bus_wdata,
  output logic [NUM_SRC-1:0]  bus_rdata,
  output logic                irq_norm_o,
  output logic                irq_crit_o
);
  logic [NUM_SRC-1:0] req_map, req_eff;
  logic [NUM_SRC-1:0] status_q, en_q, crit_q, pol_q, trig_q, vcfg_q, vec_val;
  logic [NUM_SRC-1:0] masked, norm_pend, crit_pend;

  generate
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
      assign req_map[NUM_SRC-1-n] = irq_in[n];
    end
  endgenerate

  assign req_eff = req_map ^ pol_q;

  ivc_cfg_regs #(.W(NUM_SRC), .VEC_EN(VEC_EN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .enable_o(en_q), .crit_o(crit_q),
    .pol_o(pol_q), .trig_o(trig_q), .vcfg_o(vcfg_q)
  );

  ivc_status #(.W(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .req_i(req_eff), .trig_i(trig_q),
    .clr_we_i(bus_we && (bus_addr == OFS_STATUS)),
    .set_we_i(bus_we && (bus_addr == OFS_SET)),
    .wdata_i(bus_wdata), .status_o(status_q)
  );

  always_comb begin
    masked    = status_q & en_q;
    norm_pend = masked & ~crit_q;
    crit_pend = masked & crit_q;
  end

  ivc_vector #(.W(NUM_SRC), .VEC_EN(VEC_EN)) u_vec (
    .crit_pend_i(crit_pend), .vcfg_i(vcfg_q), .vec_o(vec_val)
  );

  assign irq_norm_o = |norm_pend;
  assign irq_crit_o = |crit_pend;

  always_comb begin
    unique case (bus_addr)
      OFS_STATUS, OFS_SET: bus_rdata = status_q;
      OFS_ENABLE:          bus_rdata = en_q;
      OFS_CRIT:            bus_rdata = crit_q;
      OFS_POL:             bus_rdata = pol_q;
      OFS_TRIG:            bus_rdata = trig_q;
      OFS_MASKED:          bus_rdata = masked;
      OFS_VECTOR:          bus_rdata = vec_val;
      OFS_VCFG:            bus_rdata = vcfg_q;
      default:             bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_we,
  input logic [3:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] status,
  input logic [W-1:0] trig,
  input logic [W-1:0] vec,
  input logic [W-1:0] vcfg,
  input logic         norm,
  input logic         crit
);
  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 4'd0) |=> (($past(status & trig)) & ~status) == '0);

  p_set_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd1) |=> (status & $past(bus_wdata)) == $past(bus_wdata));

  p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd2 && bus_wdata == '0) |=> (!norm && !crit));

  p_vec_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !crit |-> vec == '0);

  p_vcfg_bit1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vcfg[1] == 1'b0);
endmodule

bind irq_vector_ctrl ivc_checker #(.W(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .status(status_q), .trig(trig_q),
  .vec(vec_val), .vcfg(vcfg_q), .norm(irq_norm_o), .crit(irq_crit_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_nv;
  logic        irq_norm_o, irq_crit_o, norm_nv, crit_nv;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o)
  );

  irq_vector_ctrl #(.VEC_EN(1'b0)) dut_nv (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata_nv),
    .irq_norm_o(norm_nv), .irq_crit_o(crit_nv)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [31:0] lines);
    @(negedge clk);
    irq_in = lines;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R12 reset/unused read", v, 32'h0);
    end
    check("R12 outputs after reset", {30'b0, irq_norm_o, irq_crit_o}, 32'h0);
  endtask

  task automatic t_level;
    wr(4'd2, 32'hFFFF_FFFF);
    drive(32'h0000_0001);
    rd(4'd0, v); check("R1 R3 level input 0 -> bit 31", v, 32'h8000_0000);
    check("R7 normal high", {31'b0, irq_norm_o}, 32'h1);
    drive(32'h0000_0000);
    rd(4'd0, v); check("R3 level follows release", v, 32'h0);
    check("R7 normal low", {31'b0, irq_norm_o}, 32'h0);
  endtask

  task automatic t_edge;
    wr(4'd5, 32'h0000_0001);
    drive(32'h8000_0000);
    drive(32'h0000_0000);
    rd(4'd0, v); check("R2 edge latched after fall", v, 32'h0000_0001);
    wr(4'd0, 32'h0000_0001);
    rd(4'd0, v); check("R4 edge cleared by write", v, 32'h0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_w1c_level;
    drive(32'h0000_0001);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd1, v); check("R4 R5 held level re-set after clear", v, 32'h8000_0000);
    drive(32'h0000_0000);
    rd(4'd0, v); check("R3 released", v, 32'h0);
  endtask

  task automatic t_set_masked;
    wr(4'd2, 32'h0000_0300);
    wr(4'd1, 32'h0000_0F00);
    rd(4'd0, v); check("R5 status-set", v, 32'h0000_0F00);
    rd(4'd6, v); check("R6 masked read", v, 32'h0000_0300);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R6 ignored writes keep status", v, 32'h0000_0F00);
    rd(4'd2, v); check("R6 ignored writes keep enable", v, 32'h0000_0300);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_route;
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0000_00F0);
    wr(4'd1, 32'h0000_0010);
    check("R7 critical only", {30'b0, irq_norm_o, irq_crit_o}, 32'h1);
    wr(4'd1, 32'h0000_0001);
    check("R7 both", {30'b0, irq_norm_o, irq_crit_o}, 32'h3);
    wr(4'd0, 32'hFFFF_FFFF);
    check("R7 none", {30'b0, irq_norm_o, irq_crit_o}, 32'h0);
  endtask

  task automatic t_vector;
    wr(4'd8, 32'h2000_0002);
    rd(4'd8, v); check("R10 bit1 forced 0", v, 32'h2000_0000);
    rd(4'd7, v); check("R9 no critical -> 0", v, 32'h0);
    wr(4'd1, 32'h0000_0050);
    rd(4'd7, v); check("R8 upward scan", v, 32'h2000_0800);
    wr(4'd8, 32'h2000_0003);
    rd(4'd8, v); check("R10 stored config", v, 32'h2000_0001);
    rd(4'd7, v); check("R8 downward scan", v, 32'h2000_3200);
    wr(4'd0, 32'h0000_0050);
    rd(4'd7, v); check("R9 cleared -> 0", v, 32'h0);
    wr(4'd8, 32'h1234_5679);
    bus_addr = 4'd8; #1; check("R12 no-vector config reads 0", rdata_nv, 32'h0);
    wr(4'd1, 32'h0000_0010);
    bus_addr = 4'd7; #1; check("R12 no-vector vector reads 0", rdata_nv, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_polarity;
    wr(4'd4, 32'h4000_0000);
    @(negedge clk);
    rd(4'd0, v); check("R11 inverted idle line sets", v, 32'h4000_0000);
    drive(32'h0000_0002);
    rd(4'd0, v); check("R11 inverted asserted line clears", v, 32'h0);
    drive(32'h0000_0000);
    wr(4'd4, 32'h0);
    @(negedge clk);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R11 restored", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_w1c_level();
    t_set_masked();
    t_route();
    t_vector();
    t_polarity();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule